// File: doc/BRIEF.md
# SPI command-decoding board controller

This block is the SPI slave of a board-support logic device. A host selects it with chip-select, clocks in SPI mode 0 (clock idles low, data sampled on the rising edge, eight bits per byte, most significant bit first), and the first byte of every selected frame is an opcode. The opcode picks what the following bytes mean. They can be a new value for the 8-bit configuration register, whose bits drive four LED enables, a fan enable and the NAND control pins. They can be data streamed to or from a byte-wide NAND data port, or a 24-bit address followed by a stream of bytes read from an addressed byte source. Two further opcodes switch a separate fifth LED output on and off.

The SPI pins are brought into the system clock domain through synchronisers, and every edge is detected there, so the system clock has to run at least four times the SCK rate. Data flowing out to NAND uses a valid/ready port. `nwr_valid` stays high with `nwr_data` unchanged until the sink raises `nwr_ready`. SPI cannot be paused, so a byte that becomes due while an earlier one is still unaccepted is dropped. Two rules apply to the sink: a sink that keeps up must accept each byte within one SPI byte time, and it may hold `nwr_ready` high all the time. Both read ports are show-ahead sources. At the first clock edge of a data byte the block takes the presented byte, asserting ready for a single system cycle, and only does so when valid is high. If valid is low, the block sends 0x00 and takes nothing.

Top module: `spi_board_ctrl`

## Requirements
- R1: Bytes are assembled MSB first from MOSI on SCK rising edges while chip-select is low; the first byte of a frame is the opcode.
- R2: After reset the configuration reads 0x8F (LED enables 0-3 high, fan 0, ALE 0, CLE 0, chip-enable-low 1), the fifth LED is off, MISO is 0 and no port strobe or valid is active.
- R3: Opcode 0x09 loads the next byte into the configuration register, with bits 3:0 to `led_n`, bit 4 to `fan_en`, bit 5 to `nand_ale`, bit 6 to `nand_cle` and bit 7 to `nand_ce_n`; later bytes of that frame change nothing.
- R4: Opcode 0x0C turns `led5_on` on and 0x0D turns it off, without touching the configuration.
- R5: After opcode 0x08 each received byte is offered on the NAND write port only when the following byte completes, so the last byte before chip-select rises is never written. `nwr_valid` stays high with stable `nwr_data` until `nwr_ready` is high, and a byte that becomes due while the port is still held is dropped.
- R6: After opcode 0x0A one idle byte follows. From the next byte on, every byte start takes one byte from the NAND read port with a one-cycle `nrd_ready` and shifts it out on MISO; if no byte is valid, 0x00 is sent.
- R7: After opcode 0x0B three address bytes, most significant first, form `fr_addr`, one dummy byte follows, and then each byte start takes one byte from the fast-read port with a one-cycle `fr_ready` and shifts it out on MISO.
- R8: `fr_addr` increases by one after every byte taken from the fast-read port.
- R9: MISO carries 0x00 during opcode, configuration, address, dummy, idle and write bytes, and stays 0 while deselected.
- R10: Raising chip-select aborts the command and the next frame starts with a fresh opcode; an unknown opcode is ignored up to the end of its frame. A byte whose last rising edge is seen in the same cycle as the release still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI clock, idle low |
| spi_cs_n | input | 1 | SPI chip-select, active low |
| spi_mosi | input | 1 | SPI data from host |
| spi_miso | output | 1 | SPI data to host |
| led_n | output | 4 | LED enables 1-4, active low (config bits 3:0) |
| fan_en | output | 1 | Fan enable (config bit 4) |
| nand_ale | output | 1 | NAND address latch enable (config bit 5) |
| nand_cle | output | 1 | NAND command latch enable (config bit 6) |
| nand_ce_n | output | 1 | NAND chip enable, active low (config bit 7) |
| led5_on | output | 1 | Fifth LED, high when on |
| nwr_valid | output | 1 | NAND write byte valid |
| nwr_ready | input | 1 | NAND write sink accepts the byte |
| nwr_data | output | 8 | NAND write byte |
| nrd_valid | input | 1 | NAND read byte available |
| nrd_ready | output | 1 | NAND read strobe, byte taken |
| nrd_data | input | 8 | NAND read byte |
| fr_addr | output | 24 | Fast-read byte address |
| fr_valid | input | 1 | Fast-read byte available |
| fr_ready | output | 1 | Fast-read byte taken |
| fr_data | input | 8 | Fast-read byte at `fr_addr` |

## Verification
The 8th rising SCK edge of a frame's last byte and the chip-select release can reach the system domain in the same clock cycle. The bench provokes this by raising chip-select at the very instant of that SCK edge, so both go through the synchronisers together. Three outcomes are judged at the ports: a configuration byte still loads, a fifth-LED opcode still switches, and in a NAND write the completing byte still releases the byte held before it while being discarded itself.

// File: rtl/spi_board_ctrl_pkg.sv
package spi_board_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_OPCODE,
    ST_CFG,
    ST_NWR,
    ST_NRD_IDLE,
    ST_NRD_DATA,
    ST_FADDR,
    ST_FDATA,
    ST_SKIP
  } dec_state_t;

  localparam logic [7:0] OP_NAND_WR  = 8'h08;
  localparam logic [7:0] OP_CFG_WR   = 8'h09;
  localparam logic [7:0] OP_NAND_RD  = 8'h0A;
  localparam logic [7:0] OP_FAST_RD  = 8'h0B;
  localparam logic [7:0] OP_LED5_ON  = 8'h0C;
  localparam logic [7:0] OP_LED5_OFF = 8'h0D;

  localparam logic [7:0] CFG_RESET = 8'h8F;

  localparam int CFG_FAN_BIT = 4;
  localparam int CFG_ALE_BIT = 5;
  localparam int CFG_CLE_BIT = 6;
  localparam int CFG_CE_BIT  = 7;

endpackage

// File: rtl/spi_bc_sync.sv
module spi_bc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic cs_n_i,
  input  logic mosi_i,
  output logic sck_rise,
  output logic sck_fall,
  output logic sel,
  output logic sel_prev,
  output logic mosi_s
);
  // bit 0 = sck, bit 1 = cs_n, bit 2 = mosi
  localparam logic [2:0] PIPE_RST = 3'b010;

  logic [2:0] pipe [STAGES];
  logic [1:0] last_q;
  logic [2:0] cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= PIPE_RST;
      last_q <= PIPE_RST[1:0];
    end else begin
      pipe[0] <= {mosi_i, cs_n_i, sck_i};
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      last_q <= pipe[STAGES-1][1:0];
    end
  end

  assign cur      = pipe[STAGES-1];
  assign sck_rise = cur[0] & ~last_q[0];
  assign sck_fall = ~cur[0] & last_q[0];
  assign sel      = ~cur[1];
  assign sel_prev = ~last_q[1];
  assign mosi_s   = cur[2];

endmodule

// File: rtl/spi_bc_shifter.sv
module spi_bc_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              sel,
  input  logic              sel_prev,
  input  logic              mosi_s,
  input  logic [DATA_W-1:0] tx_next,
  output logic              byte_done,
  output logic              byte_start,
  output logic [DATA_W-1:0] rx_byte,
  output logic              miso
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  logic [BIT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] rx_sr;
  logic [DATA_W-1:0] tx_sr;
  logic              live_rise;

  assign live_rise  = sck_rise & sel_prev;
  assign byte_done  = live_rise & (bit_cnt == LAST_BIT);
  assign byte_start = live_rise & sel & (bit_cnt == '0);
  assign rx_byte    = {rx_sr[DATA_W-2:0], mosi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      rx_sr   <= '0;
      tx_sr   <= '0;
    end else if (!sel) begin
      bit_cnt <= '0;
      rx_sr   <= '0;
      tx_sr   <= '0;
    end else if (live_rise) begin
      rx_sr   <= rx_byte;
      bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
      if (bit_cnt == '0) tx_sr <= tx_next;
    end else if (sck_fall && sel_prev && bit_cnt != '0) begin
      tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
    end
  end

  // MSB of a new byte comes straight from the source so nothing is taken early
  always_comb begin
    if (!sel)                miso = 1'b0;
    else if (bit_cnt == '0)  miso = tx_next[DATA_W-1];
    else                     miso = tx_sr[DATA_W-1];
  end

endmodule

// File: rtl/spi_bc_decoder.sv
module spi_bc_decoder
  import spi_board_ctrl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              sel_prev,
  input  logic              byte_done,
  input  logic              byte_start,
  input  logic [DATA_W-1:0] rx_byte,
  output logic [DATA_W-1:0] tx_next,
  output logic [DATA_W-1:0] cfg_q,
  output logic              led5_q,
  output logic              nwr_valid,
  input  logic              nwr_ready,
  output logic [DATA_W-1:0] nwr_data,
  input  logic              nrd_valid,
  output logic              nrd_ready,
  input  logic [DATA_W-1:0] nrd_data,
  output logic [ADDR_W-1:0] fr_addr,
  input  logic              fr_valid,
  output logic              fr_ready,
  input  logic [DATA_W-1:0] fr_data
);
  localparam int ADDR_BYTES = ADDR_W / DATA_W;
  localparam int CNT_W      = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] DUMMY_IDX = CNT_W'(ADDR_BYTES);

  dec_state_t        st;
  logic [CNT_W-1:0]  acnt;
  logic [DATA_W-1:0] hold_q;
  logic              hold_v;
  logic              frame_end;
  logic              slot_free;

  assign frame_end = sel_prev & ~sel;
  assign slot_free = ~nwr_valid | nwr_ready;

  assign nrd_ready = byte_start & (st == ST_NRD_DATA) & nrd_valid;
  assign fr_ready  = byte_start & (st == ST_FDATA) & fr_valid;

  always_comb begin
    tx_next = '0;
    if (st == ST_NRD_DATA && nrd_valid) tx_next = nrd_data;
    else if (st == ST_FDATA && fr_valid) tx_next = fr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_OPCODE;
      cfg_q     <= CFG_RESET;
      led5_q    <= 1'b0;
      acnt      <= '0;
      hold_q    <= '0;
      hold_v    <= 1'b0;
      nwr_valid <= 1'b0;
      nwr_data  <= '0;
      fr_addr   <= '0;
    end else begin
      if (nwr_valid && nwr_ready) nwr_valid <= 1'b0;

      if (byte_done) begin
        unique case (st)
          ST_OPCODE: begin
            acnt <= '0;
            case (rx_byte)
              OP_CFG_WR:   st <= ST_CFG;
              OP_NAND_WR:  st <= ST_NWR;
              OP_NAND_RD:  st <= ST_NRD_IDLE;
              OP_FAST_RD:  st <= ST_FADDR;
              OP_LED5_ON:  begin led5_q <= 1'b1; st <= ST_SKIP; end
              OP_LED5_OFF: begin led5_q <= 1'b0; st <= ST_SKIP; end
              default:     st <= ST_SKIP;
            endcase
          end
          ST_CFG: begin
            cfg_q <= rx_byte;
            st    <= ST_SKIP;
          end
          ST_NWR: begin
            if (hold_v && slot_free) begin
              nwr_valid <= 1'b1;
              nwr_data  <= hold_q;
            end
            hold_q <= rx_byte;
            hold_v <= 1'b1;
          end
          ST_NRD_IDLE: st <= ST_NRD_DATA;
          ST_FADDR: begin
            if (acnt == DUMMY_IDX) begin
              st <= ST_FDATA;
            end else begin
              fr_addr <= {fr_addr[ADDR_W-DATA_W-1:0], rx_byte};
              acnt    <= acnt + 1'b1;
            end
          end
          default: ;
        endcase
      end

      if (fr_ready) fr_addr <= fr_addr + 1'b1;

      if (frame_end) begin
        st     <= ST_OPCODE;
        hold_v <= 1'b0;
        acnt   <= '0;
      end
    end
  end

endmodule

// File: rtl/spi_board_ctrl.sv
module spi_board_ctrl
  import spi_board_ctrl_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic [3:0]        led_n,
  output logic              fan_en,
  output logic              nand_ale,
  output logic              nand_cle,
  output logic              nand_ce_n,
  output logic              led5_on,
  output logic              nwr_valid,
  input  logic              nwr_ready,
  output logic [DATA_W-1:0] nwr_data,
  input  logic              nrd_valid,
  output logic              nrd_ready,
  input  logic [DATA_W-1:0] nrd_data,
  output logic [ADDR_W-1:0] fr_addr,
  input  logic              fr_valid,
  output logic              fr_ready,
  input  logic [DATA_W-1:0] fr_data
);
  logic              sck_rise, sck_fall, sel, sel_prev, mosi_s;
  logic              byte_done, byte_start;
  logic [DATA_W-1:0] rx_byte, tx_next, cfg_q;

  spi_bc_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n),
    .sck_i(spi_sck), .cs_n_i(spi_cs_n), .mosi_i(spi_mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall),
    .sel(sel), .sel_prev(sel_prev), .mosi_s(mosi_s)
  );

  spi_bc_shifter #(.DATA_W(DATA_W)) i_shift (
    .clk(clk), .rst_n(rst_n),
    .sck_rise(sck_rise), .sck_fall(sck_fall),
    .sel(sel), .sel_prev(sel_prev), .mosi_s(mosi_s),
    .tx_next(tx_next),
    .byte_done(byte_done), .byte_start(byte_start),
    .rx_byte(rx_byte), .miso(spi_miso)
  );

  spi_bc_decoder #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_dec (
    .clk(clk), .rst_n(rst_n),
    .sel(sel), .sel_prev(sel_prev),
    .byte_done(byte_done), .byte_start(byte_start),
    .rx_byte(rx_byte), .tx_next(tx_next),
    .cfg_q(cfg_q), .led5_q(led5_on),
    .nwr_valid(nwr_valid), .nwr_ready(nwr_ready), .nwr_data(nwr_data),
    .nrd_valid(nrd_valid), .nrd_ready(nrd_ready), .nrd_data(nrd_data),
    .fr_addr(fr_addr), .fr_valid(fr_valid), .fr_ready(fr_ready),
    .fr_data(fr_data)
  );

  assign led_n     = cfg_q[3:0];
  assign fan_en    = cfg_q[CFG_FAN_BIT];
  assign nand_ale  = cfg_q[CFG_ALE_BIT];
  assign nand_cle  = cfg_q[CFG_CLE_BIT];
  assign nand_ce_n = cfg_q[CFG_CE_BIT];

endmodule

// File: rtl/spi_board_ctrl_chk.sv
module spi_board_ctrl_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spi_cs_n,
  input logic              spi_miso,
  input logic              nwr_valid,
  input logic              nwr_ready,
  input logic [DATA_W-1:0] nwr_data,
  input logic              nrd_ready,
  input logic              fr_ready,
  input logic [ADDR_W-1:0] fr_addr
);

  // R5: an unaccepted write byte stays offered and unchanged
  p_wr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    nwr_valid && !nwr_ready |=> nwr_valid && $stable(nwr_data));

  // R6: one read strobe per byte start, never two cycles running
  p_rd_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    nrd_ready |=> !nrd_ready);

  // R7: one fast-read take per byte start
  p_fr_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fr_ready |=> !fr_ready);

  // R8: address advances by one after each take
  p_addr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fr_ready |=> fr_addr == $past(fr_addr) + 1'b1);

  // R9: MISO quiet once deselect has passed the synchronisers
  p_miso_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)
    |-> !spi_miso);

endmodule

bind spi_board_ctrl spi_board_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_spi_board_ctrl.sv
module test_spi_board_ctrl;
  localparam time CLK_HALF = 2.5ns;
  localparam time SCK_HALF = 40ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso;
  logic [3:0] led_n;
  logic fan_en, nand_ale, nand_cle, nand_ce_n, led5_on;
  logic nwr_valid, nwr_ready;
  logic [7:0] nwr_data;
  logic nrd_valid, nrd_ready;
  logic [7:0] nrd_data;
  logic [23:0] fr_addr;
  logic fr_valid, fr_ready;
  logic [7:0] fr_data;

  int compared = 0, mismatched = 0;
  logic wr_ready_b = 1'b1, rd_valid_b = 1'b1;
  int wr_cnt = 0, rd_idx = 0;
  logic [7:0] wr_log [16];
  logic [7:0] txb [16];
  logic [7:0] rxb [16];

  always #CLK_HALF clk = ~clk;

  assign nwr_ready = wr_ready_b;
  assign nrd_valid = rd_valid_b;
  assign nrd_data  = 8'hA0 + rd_idx[7:0];
  assign fr_valid  = 1'b1;
  assign fr_data   = fr_addr[7:0] ^ 8'h5A;

  always @(posedge clk) begin
    if (nwr_valid && nwr_ready) begin
      if (wr_cnt < 16) wr_log[wr_cnt] <= nwr_data;
      wr_cnt <= wr_cnt + 1;
    end
    if (nrd_valid && nrd_ready) rd_idx <= rd_idx + 1;
  end

  spi_board_ctrl i_spi_board_ctrl (.*);

  function automatic logic [7:0] cfg_now();
    return {nand_ce_n, nand_cle, nand_ale, fan_en, led_n};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic frame(input int n, input bit coincide);
    @(posedge clk); #2;
    spi_cs_n = 1'b0;
    #SCK_HALF;
    for (int b = 0; b < n; b++) begin
      for (int i = 7; i >= 0; i--) begin
        spi_mosi = txb[b][i];
        #SCK_HALF;
        if (coincide && b == n - 1 && i == 0) spi_cs_n = 1'b1;
        spi_sck = 1'b1;
        rxb[b][i] = spi_miso;
        #SCK_HALF;
        spi_sck = 1'b0;
      end
    end
    if (!coincide) begin
      #SCK_HALF;
      spi_cs_n = 1'b1;
    end
    spi_mosi = 1'b0;
    #(SCK_HALF * 4);
  endtask

  task automatic t_reset();
    chk("R2 cfg", cfg_now(), 8'h8F);
    chk("R2 led5", led5_on, 0);
    chk("R2 miso", spi_miso, 0);
    chk("R2 strobes", {nwr_valid, nrd_ready, fr_ready}, 0);
  endtask

  task automatic t_cfg();
    txb[0] = 8'h09; txb[1] = 8'h5A; txb[2] = 8'h33;
    frame(3, 0);
    chk("R3 cfg 5A, trailing byte ignored", cfg_now(), 8'h5A);
    chk("R3 field fan", fan_en, 1);
    chk("R3 field cle", nand_cle, 1);
    chk("R9 miso zero on cfg frame", {rxb[0], rxb[1], rxb[2]}, 0);
    txb[0] = 8'h09; txb[1] = 8'h21;
    frame(2, 0);
    chk("R1 msb-first byte 21", cfg_now(), 8'h21);
    chk("R3 field ale", nand_ale, 1);
  endtask

  task automatic t_led5();
    txb[0] = 8'h0C;
    frame(1, 0);
    chk("R4 led5 on", led5_on, 1);
    chk("R4 cfg untouched", cfg_now(), 8'h21);
    txb[0] = 8'h0D;
    frame(1, 0);
    chk("R4 led5 off", led5_on, 0);
  endtask

  task automatic t_nwr();
    int base;
    base = wr_cnt;
    txb[0] = 8'h08; txb[1] = 8'h11; txb[2] = 8'h22; txb[3] = 8'h33; txb[4] = 8'hFF;
    frame(5, 0);
    chk("R5 write count", wr_cnt - base, 3);
    chk("R5 write bytes", {wr_log[base], wr_log[base+1], wr_log[base+2]}, 24'h112233);
    chk("R9 miso zero on write", {rxb[1], rxb[2], rxb[3], rxb[4]}, 0);
    base = wr_cnt;
    wr_ready_b = 1'b0;
    txb[1] = 8'h44; txb[2] = 8'h55; txb[3] = 8'h66; txb[4] = 8'hEE;
    frame(5, 0);
    chk("R5 held byte offered", {nwr_valid, nwr_data}, 9'h144);
    @(negedge clk); wr_ready_b = 1'b1;
    repeat (4) @(negedge clk);
    chk("R5 later bytes dropped", wr_cnt - base, 1);
    chk("R5 accepted byte", wr_log[base], 8'h44);
  endtask

  task automatic t_nrd();
    int base;
    base = rd_idx;
    txb[0] = 8'h0A; txb[1] = 8'h00; txb[2] = 8'h00; txb[3] = 8'h00; txb[4] = 8'h00;
    frame(5, 0);
    chk("R6 strobe count", rd_idx - base, 3);
    chk("R6 data on miso", {rxb[2], rxb[3], rxb[4]},
        {8'hA0 + 8'(base), 8'hA1 + 8'(base), 8'hA2 + 8'(base)});
    chk("R9 miso zero opcode/idle", {rxb[0], rxb[1]}, 0);
    base = rd_idx;
    rd_valid_b = 1'b0;
    frame(3, 0);
    chk("R6 no valid sends zero", rxb[2], 0);
    chk("R6 no valid no strobe", rd_idx - base, 0);
    rd_valid_b = 1'b1;
  endtask

  task automatic t_frd();
    txb[0] = 8'h0B; txb[1] = 8'h01; txb[2] = 8'h23; txb[3] = 8'h45; txb[4] = 8'h00;
    txb[5] = 8'h00; txb[6] = 8'h00; txb[7] = 8'h00;
    frame(8, 0);
    chk("R7 fast data", {rxb[5], rxb[6], rxb[7]}, 24'h1F1C1D);
    chk("R9 miso zero addr/dummy", {rxb[0], rxb[1], rxb[2], rxb[3], rxb[4]}, 0);
    chk("R8 address after three takes", fr_addr, 24'h012348);
  endtask

  task automatic t_abort();
    int base;
    txb[0] = 8'h0B; txb[1] = 8'h77;
    frame(2, 0);
    txb[0] = 8'h09; txb[1] = 8'h0F;
    frame(2, 0);
    chk("R10 abort then fresh opcode", cfg_now(), 8'h0F);
    txb[0] = 8'h55; txb[1] = 8'h09; txb[2] = 8'h00;
    frame(3, 0);
    chk("R10 unknown opcode ignored", cfg_now(), 8'h0F);
    base = wr_cnt;
    txb[0] = 8'h08; txb[1] = 8'hAA;
    frame(2, 0);
    chk("R10 short write discarded", wr_cnt - base, 0);
  endtask

  task automatic t_coincide();
    int base;
    txb[0] = 8'h09; txb[1] = 8'hC3;
    frame(2, 1);
    chk("R10 cfg byte at release", cfg_now(), 8'hC3);
    txb[0] = 8'h0C;
    frame(1, 1);
    chk("R10 led5 opcode at release", led5_on, 1);
    base = wr_cnt;
    txb[0] = 8'h08; txb[1] = 8'h12; txb[2] = 8'h34;
    frame(3, 1);
    chk("R10 R5 write at release count", wr_cnt - base, 1);
    chk("R10 R5 write at release byte", wr_log[base], 8'h12);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(CLK_HALF * 2 * 200000);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_cfg();
    t_led5();
    t_nwr();
    t_nrd();
    t_frd();
    t_abort();
    t_coincide();
    summary();
  end

endmodule